// File: doc/BRIEF.md
# Four-Byte Addressed Register File

A small memory of four byte-wide registers, selected by a two-bit binary address. A single byte value input feeds every register. An independent write strobe stores that value into the addressed register on the rising clock edge. A separate read strobe gates the addressed register onto the byte output. While the read strobe is low, the output is forced to zero.

The address is decoded twice into one-hot enables: once for writing and once for reading. Each storage bit keeps its value by feeding itself back whenever its write enable is low. The read path is combinational. A read issued in the same cycle as a write to the same address therefore returns the value held before the edge. An active-low asynchronous reset clears all four registers.

Top module: `quad_byte_ram`

## Requirements
- R1: While rst_ni is low, all four registers are cleared to 0x00, and every address reads 0x00 once reset is released.
- R2: With save_i high at a rising clock edge, the register at binary index addr_i (0 to 3) takes the value of wdata_i.
- R3: A write changes only the addressed register; the other three keep their contents.
- R4: With save_i low at a clock edge, no register changes, whatever wdata_i and addr_i are.
- R5: With load_i high, rdata_o equals the register at index addr_i, combinationally.
- R6: With load_i low, rdata_o is 0x00 regardless of the stored contents and the address.
- R7: With save_i and load_i both high on one address, rdata_o shows the old contents during that cycle, and the new value is readable after the edge.
- R8: Each enabled address decoder drives exactly one of its four select lines; a disabled decoder drives none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register index, binary 0..3 |
| wdata_i | input | 8 | Byte to store |
| save_i | input | 1 | Write strobe |
| load_i | input | 1 | Read strobe, gates the output |
| rdata_o | output | 8 | Addressed register when reading, else 0x00 |

## Verification
Directed writes of distinct patterns such as 0x11, 0x22, 0x44 and 0x88 to each index, followed by reads of all four, tell a correct decode apart from aliased or swapped addresses. Writes with save_i low, carrying values that differ from the stored ones, show whether the hold path leaks. Reads with load_i low after non-zero data has been stored separate a gated output from one that merely reads zeros. Random mixes of address, data and strobes, including save and load together on one index, check the old-value read order against a shadow model in the bench.

// File: rtl/quad_byte_ram_pkg.sv
package quad_byte_ram_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned ADDR_W_DEF = 2;
endpackage

// File: rtl/rf_decoder.sv
module rf_decoder #(
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  output logic [DEPTH-1:0]  sel_o
);
  for (genvar k = 0; k < DEPTH; k++) begin : g_line
    assign sel_o[k] = en_i && (addr_i == ADDR_W'(k));
  end
endmodule

// File: rtl/rf_cell.sv
module rf_cell #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_q, nxt;

  // recirculate unless written
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign nxt[b] = we_i ? d_i[b] : q_q[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= nxt;
  end

  assign q_o = q_q;

  p_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == $past(d_i));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] rows_i,
  input  logic [DEPTH-1:0]             sel_i,
  output logic [DATA_W-1:0]            rdata_o
);
  // AND-OR tree on one-hot select; no select gives zero
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      rdata_o = rdata_o | (rows_i[k] & {DATA_W{sel_i[k]}});
    end
  end
endmodule

// File: rtl/quad_byte_ram.sv
module quad_byte_ram
  import quad_byte_ram_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              save_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DEPTH-1:0]             wr_sel, rd_sel;
  logic [DEPTH-1:0][DATA_W-1:0] rows;

  rf_decoder #(.ADDR_W(ADDR_W)) u_wr_dec (.addr_i(addr_i), .en_i(save_i), .sel_o(wr_sel));
  rf_decoder #(.ADDR_W(ADDR_W)) u_rd_dec (.addr_i(addr_i), .en_i(load_i), .sel_o(rd_sel));

  for (genvar k = 0; k < DEPTH; k++) begin : g_row
    rf_cell #(.DATA_W(DATA_W)) u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_sel[k]),
      .d_i(wdata_i), .q_o(rows[k])
    );

    p_isolation_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (save_i && addr_i != ADDR_W'(k)) |=> $stable(rows[k]));
  end

  rf_read_mux #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd_mux (
    .rows_i(rows), .sel_i(rd_sel), .rdata_o(rdata_o)
  );

  p_onehot_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_i |-> $countones(wr_sel) == 1);
  p_onehot_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> $countones(rd_sel) == 1);
  p_idle_dec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !save_i |-> wr_sel == '0);
  p_load_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |-> rdata_o == '0);
  p_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> rdata_o == rows[addr_i]);
  p_read_old_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && load_i) |-> rdata_o == rows[addr_i]);
endmodule

// File: tb/quad_byte_ram_bench.sv
`timescale 1ns/1ps
module quad_byte_ram_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       save_i = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] rdata_o;

  int errors = 0;
  int checks = 0;
  logic [7:0] shadow [4];

  always #2.5 clk_i = ~clk_i;

  quad_byte_ram u_quad_byte_ram (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .save_i(save_i), .load_i(load_i), .rdata_o(rdata_o)
  );

  function automatic logic [7:0] exp_out(input logic ld, input logic [1:0] a);
    return ld ? shadow[a] : 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // drive at negedge, check combinational output, then apply the edge
  task automatic op(input string req, input logic [1:0] a, input logic [7:0] d,
                    input logic sv, input logic ld);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; save_i = sv; load_i = ld;
    #1 check(req, rdata_o, exp_out(ld, a));
    @(posedge clk_i);
    if (sv) shadow[a] = d;
  endtask

  task automatic read_all(input string req);
    for (int k = 0; k < 4; k++) op(req, 2'(k), 8'h00, 1'b0, 1'b1);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int k = 0; k < 4; k++) shadow[k] = 8'h00;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    read_all("R1");

    // R2 R3: distinct patterns per index
    op("R2", 2'd0, 8'h11, 1'b1, 1'b0);
    op("R2", 2'd1, 8'h22, 1'b1, 1'b0);
    op("R2", 2'd2, 8'h44, 1'b1, 1'b0);
    op("R2", 2'd3, 8'h88, 1'b1, 1'b0);
    read_all("R3");
    op("R3", 2'd2, 8'hFF, 1'b1, 1'b0);
    read_all("R3");

    // R4: save low with differing data
    for (int k = 0; k < 4; k++) op("R4", 2'(k), 8'h5A, 1'b0, 1'b0);
    read_all("R4");

    // R6: load low hides non-zero contents
    for (int k = 0; k < 4; k++) op("R6", 2'(k), 8'hC3, 1'b0, 1'b0);

    // R5 R7: save and load together return old, then new
    op("R7", 2'd1, 8'hA5, 1'b1, 1'b1);
    op("R5", 2'd1, 8'h00, 1'b0, 1'b1);
    op("R7", 2'd3, 8'h00, 1'b1, 1'b1);
    op("R5", 2'd3, 8'h00, 1'b0, 1'b1);

    // R8: each index selectable in turn, no aliasing
    for (int k = 0; k < 4; k++) op("R8", 2'(k), 8'(8'h30 + k), 1'b1, 1'b0);
    read_all("R8");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [1:0] a;
      logic [7:0] d;
      logic sv, ld;
      a  = 2'($urandom_range(0, 3));
      d  = 8'($urandom);
      sv = 1'($urandom);
      ld = 1'($urandom);
      op(sv && ld ? "R7" : (ld ? "R5" : "R6"), a, d, sv, ld);
    end
    read_all("R3");

    // R1: asynchronous reset mid-run
    @(negedge clk_i);
    save_i = 1'b0; load_i = 1'b0;
    rst_ni = 1'b0;
    for (int k = 0; k < 4; k++) shadow[k] = 8'h00;
    @(negedge clk_i);
    rst_ni = 1'b1;
    read_all("R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule